// File: doc/BRIEF.md
# Transmit Error Halt Handler

This block sits between a descriptor-driven transmit queue and the MAC transmit datapath. It watches for two faults. One is a transmit underrun: the data FIFO runs dry while a frame is on the wire, or the descriptor fetcher stalls before the frame's chain is complete. The other is a collision retry limit that has been used up. On either fault it takes the recovery action, closes the current buffer with a status bit, raises sticky event flags and halts the queue.

An underrun in the middle of a frame makes the block ask the CRC stage to invert its remainder for a 32-bit tail. This forces a bad CRC, and the frame is then killed. An underrun caused by the descriptor chain only halts the queue. A retry-limit fault ends the frame at once. Transmission resumes only when software has cleared the halt and the graceful-stop control is also low.

Top module: `tx_fault_halt`

## Requirements
- R1: After reset, queueHalted, bufClose, bufUn, bufRl, tailInvert, frameKill and all evFlags bits are 0, and txEnable is 1 while gracefulStop is 0.
- R2: A mid-frame underrun is frameActive=1 with fifoValid=0 while the queue is not halted. From the next cycle it drives tailInvert high for exactly TAIL_BITS/LANE_W cycles (4 by default). frameKill then pulses for one cycle.
- R3: A descriptor underrun is chainStall=1 with chainDone=0 while the queue is not halted. It halts the queue and closes the buffer, but raises neither tailInvert nor frameKill. chainStall with chainDone=1 has no effect.
- R4: Any underrun gives, in the next cycle, a one-cycle bufClose with bufUn=1 and bufRl=0. It sets evFlags[0] (underrun) and evFlags[2] (transmit error).
- R5: retryLimit=1 while the queue is not halted gives, in the next cycle, a one-cycle bufClose with bufRl=1 and bufUn=0, together with a one-cycle frameKill and no tail. It sets evFlags[1] (retry limit) and evFlags[2].
- R6: If an underrun and a retry-limit fault fall in the same cycle, the buffer status is retry-limit only (bufRl=1, bufUn=0), no tail is produced, and evFlags[0], [1] and [2] are all set.
- R7: queueHalted rises in the same cycle as bufClose. While halted, fault inputs cause no bufClose, no tail and no flag change.
- R8: A haltClear pulse while halted clears queueHalted in the next cycle. txEnable is 1 only when queueHalted is 0 and gracefulStop is 0.
- R9: Each evFlags bit stays set until a 1 is written to the same bit of evClear. A fault that sets a bit wins over a clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoValid | input | 1 | Transmit FIFO has data for the current beat |
| frameActive | input | 1 | A frame is being sent on the wire |
| chainDone | input | 1 | The descriptor chain of the current frame is complete |
| chainStall | input | 1 | Descriptor fetcher found no ready descriptor |
| retryLimit | input | 1 | Collision retry limit exhausted (pulse) |
| haltClear | input | 1 | Software strobe clearing the halt |
| gracefulStop | input | 1 | Graceful-stop control level |
| evClear | input | 3 | Write-one-to-clear mask for evFlags |
| tailInvert | output | 1 | CRC stage must invert its remainder for this beat |
| frameKill | output | 1 | Terminate the current frame (pulse) |
| bufClose | output | 1 | Close the current buffer (pulse) |
| bufUn | output | 1 | Buffer status: underrun (valid with bufClose) |
| bufRl | output | 1 | Buffer status: retry limit (valid with bufClose) |
| evFlags | output | 3 | Sticky events: [0] underrun, [1] retry limit, [2] transmit error |
| queueHalted | output | 1 | Queue halted |
| txEnable | output | 1 | Queue may transmit |

## Verification
The two functions that can fall in one cycle are mid-frame underrun detection and retry-limit detection. The bench provokes both at once by holding frameActive high with fifoValid low in the same cycle that it pulses retryLimit. It then judges the result cycle by cycle against its model: the status must be retry only, all three flags must be set, and no inverted tail may follow. A second overlap, a fault setting a flag in the same cycle that evClear clears that flag, is provoked the same way, and the flag must stay set.

// File: rtl/txh_pkg.sv
package txh_pkg;
  localparam int EV_UNDER = 0;
  localparam int EV_RETRY = 1;
  localparam int EV_TXERR = 2;
  localparam int EV_COUNT = 3;

  typedef struct packed {
    logic closeBuf;
    logic statUnder;
    logic statRetry;
    logic evUnder;
    logic evRetry;
    logic startTail;
    logic killNow;
  } txhStrobes_t;
endpackage

// File: rtl/txh_ctrl.sv
module txh_ctrl
  import txh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoValid,
  input  logic        frameActive,
  input  logic        chainDone,
  input  logic        chainStall,
  input  logic        retryLimit,
  input  logic        haltClear,
  input  logic        gracefulStop,
  output txhStrobes_t strb,
  output logic        queueHalted,
  output logic        txEnable
);
  logic haltQ;
  logic midUnder, chainUnder, retryHit, anyUnder, anyErr;

  always_comb begin
    midUnder   = !haltQ && frameActive && !fifoValid;
    chainUnder = !haltQ && chainStall && !chainDone;
    retryHit   = !haltQ && retryLimit;
    anyUnder   = midUnder || chainUnder;
    anyErr     = anyUnder || retryHit;
  end

  always_comb begin
    strb.closeBuf  = anyErr;
    strb.statRetry = retryHit;
    strb.statUnder = anyUnder && !retryHit;
    strb.evUnder   = anyUnder;
    strb.evRetry   = retryHit;
    strb.startTail = midUnder && !retryHit;
    strb.killNow   = retryHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          haltQ <= 1'b0;
    else if (anyErr)    haltQ <= 1'b1;
    else if (haltClear) haltQ <= 1'b0;
  end

  assign queueHalted = haltQ;
  assign txEnable    = !haltQ && !gracefulStop;
endmodule

// File: rtl/txh_dpath.sv
module txh_dpath
  import txh_pkg::*;
#(
  parameter int TAIL_BITS = 32,
  parameter int LANE_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  txhStrobes_t         strb,
  input  logic [EV_COUNT-1:0] evClear,
  output logic                tailInvert,
  output logic                frameKill,
  output logic                bufClose,
  output logic                bufUn,
  output logic                bufRl,
  output logic [EV_COUNT-1:0] evFlags
);
  localparam int TAIL_BEATS = TAIL_BITS / LANE_W;
  localparam int CNT_W      = $clog2(TAIL_BEATS + 1);
  localparam logic [CNT_W-1:0] BEATS_V = CNT_W'(TAIL_BEATS);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [CNT_W-1:0]    tailCnt;
  logic [EV_COUNT-1:0] evSet;

  always_comb begin
    evSet           = '0;
    evSet[EV_UNDER] = strb.evUnder;
    evSet[EV_RETRY] = strb.evRetry;
    evSet[EV_TXERR] = strb.closeBuf;
  end

  for (genvar i = 0; i < EV_COUNT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evFlags[i] <= 1'b0;
      else       evFlags[i] <= evSet[i] | (evFlags[i] & ~evClear[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufClose  <= 1'b0;
      bufUn     <= 1'b0;
      bufRl     <= 1'b0;
      frameKill <= 1'b0;
      tailCnt   <= '0;
    end else begin
      bufClose  <= strb.closeBuf;
      bufUn     <= strb.statUnder;
      bufRl     <= strb.statRetry;
      frameKill <= strb.killNow || (tailCnt == ONE_V);
      if (strb.startTail)    tailCnt <= BEATS_V;
      else if (tailCnt != 0) tailCnt <= tailCnt - ONE_V;
    end
  end

  assign tailInvert = (tailCnt != '0);
endmodule

// File: rtl/tx_fault_halt.sv
module tx_fault_halt
  import txh_pkg::*;
#(
  parameter int TAIL_BITS = 32,
  parameter int LANE_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fifoValid,
  input  logic                frameActive,
  input  logic                chainDone,
  input  logic                chainStall,
  input  logic                retryLimit,
  input  logic                haltClear,
  input  logic                gracefulStop,
  input  logic [EV_COUNT-1:0] evClear,
  output logic                tailInvert,
  output logic                frameKill,
  output logic                bufClose,
  output logic                bufUn,
  output logic                bufRl,
  output logic [EV_COUNT-1:0] evFlags,
  output logic                queueHalted,
  output logic                txEnable
);
  txhStrobes_t strb;

  txh_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .fifoValid(fifoValid), .frameActive(frameActive),
    .chainDone(chainDone), .chainStall(chainStall), .retryLimit(retryLimit),
    .haltClear(haltClear), .gracefulStop(gracefulStop), .strb(strb),
    .queueHalted(queueHalted), .txEnable(txEnable)
  );

  txh_dpath #(.TAIL_BITS(TAIL_BITS), .LANE_W(LANE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evClear(evClear),
    .tailInvert(tailInvert), .frameKill(frameKill), .bufClose(bufClose),
    .bufUn(bufUn), .bufRl(bufRl), .evFlags(evFlags)
  );
endmodule

// File: rtl/txh_checker.sv
module txh_checker (
  input logic       clk,
  input logic       rstN,
  input logic       haltClear,
  input logic       retryLimit,
  input logic [2:0] evClear,
  input logic       tailInvert,
  input logic       frameKill,
  input logic       bufClose,
  input logic       bufUn,
  input logic       bufRl,
  input logic [2:0] evFlags,
  input logic       queueHalted
);
  p_close_halts_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufClose |-> queueHalted);
  p_halted_no_close_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(queueHalted) && queueHalted) |-> !bufClose);
  p_status_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    bufClose |-> ($countones({bufUn, bufRl}) == 1));
  p_close_txerr_r4: assert property (@(posedge clk) disable iff (!rstN)
    bufClose |-> evFlags[2]);
  p_retry_kill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bufClose && bufRl) |-> frameKill);
  p_tail_kill_apart_r2: assert property (@(posedge clk) disable iff (!rstN)
    tailInvert |-> !frameKill);
  p_unhalt_by_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(queueHalted) |-> $past(haltClear));
  p_txerr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(evFlags[2]) && !$past(evClear[2])) |-> evFlags[2]);
  p_retry_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(retryLimit) && !$past(queueHalted)) |-> evFlags[1]);
endmodule

bind tx_fault_halt txh_checker chk_i (
  .clk(clk), .rstN(rstN), .haltClear(haltClear), .retryLimit(retryLimit),
  .evClear(evClear), .tailInvert(tailInvert), .frameKill(frameKill),
  .bufClose(bufClose), .bufUn(bufUn), .bufRl(bufRl), .evFlags(evFlags),
  .queueHalted(queueHalted)
);

// File: tb/tx_fault_halt_tb_top.sv
`timescale 1ns/100ps
module tx_fault_halt_tb_top;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoValid = 1'b1, frameActive = 1'b0, chainDone = 1'b1, chainStall = 1'b0;
  logic retryLimit = 1'b0, haltClear = 1'b0, gracefulStop = 1'b0;
  logic [2:0] evClear = 3'b000;
  logic tailInvert, frameKill, bufClose, bufUn, bufRl, queueHalted, txEnable;
  logic [2:0] evFlags;

  always #2.5 clk = ~clk;

  tx_fault_halt dut_i (
    .clk(clk), .rstN(rstN), .fifoValid(fifoValid), .frameActive(frameActive),
    .chainDone(chainDone), .chainStall(chainStall), .retryLimit(retryLimit),
    .haltClear(haltClear), .gracefulStop(gracefulStop), .evClear(evClear),
    .tailInvert(tailInvert), .frameKill(frameKill), .bufClose(bufClose),
    .bufUn(bufUn), .bufRl(bufRl), .evFlags(evFlags), .queueHalted(queueHalted),
    .txEnable(txEnable)
  );

  // reference model state
  bit mHalt = 0, mClose = 0, mUn = 0, mRl = 0, mKill = 0;
  bit [2:0] mFlags = 0;
  int mTail = 0;
  int checks = 0, failures = 0;
  int tailSeen = 0, closeSeen = 0, killSeen = 0;
  string curReq = "R1";
  bit done = 0;

  always @(posedge clk) begin
    bit under, mid, retry;
    if (!rstN) begin
      mHalt = 0; mClose = 0; mUn = 0; mRl = 0; mKill = 0; mFlags = 0; mTail = 0;
    end else begin
      mid   = !mHalt && frameActive && !fifoValid;
      under = mid || (!mHalt && chainStall && !chainDone);
      retry = !mHalt && retryLimit;
      mKill = retry || (mTail == 1);
      if (mid && !retry) mTail = BEATS;
      else if (mTail > 0) mTail = mTail - 1;
      mClose = under || retry;
      mUn = under && !retry;
      mRl = retry;
      for (int i = 0; i < 3; i++) if (evClear[i]) mFlags[i] = 0;
      if (under) mFlags[0] = 1;
      if (retry) mFlags[1] = 1;
      if (under || retry) mFlags[2] = 1;
      if (under || retry) mHalt = 1;
      else if (haltClear) mHalt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tailInvert === (mTail != 0), curReq, "tailInvert", tailInvert, mTail != 0);
    chk(frameKill === mKill, curReq, "frameKill", frameKill, mKill);
    chk({bufClose, bufUn, bufRl} === {mClose, mUn, mRl}, curReq, "close/un/rl",
        {bufClose, bufUn, bufRl}, {mClose, mUn, mRl});
    chk(evFlags === mFlags, curReq, "evFlags", evFlags, mFlags);
    chk(queueHalted === mHalt, curReq, "queueHalted", queueHalted, mHalt);
    chk(txEnable === (!mHalt && !gracefulStop), curReq, "txEnable", txEnable,
        !mHalt && !gracefulStop);
    if (tailInvert) tailSeen++;
    if (bufClose) closeSeen++;
    if (frameKill) killSeen++;
  endtask

  task automatic step(input bit fv, input bit fa, input bit cd, input bit cs,
                      input bit rl, input bit hc, input bit gs, input bit [2:0] clr);
    fifoValid = fv; frameActive = fa; chainDone = cd; chainStall = cs;
    retryLimit = rl; haltClear = hc; gracefulStop = gs; evClear = clr;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0, 0, 0, 0, 3'b000);
  endtask

  task automatic recover();
    step(1, 0, 1, 0, 0, 1, 0, 3'b111);
    idle(1);
  endtask

  task automatic zeroSeen();
    tailSeen = 0; closeSeen = 0; killSeen = 0;
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(3);
    chk(!queueHalted && evFlags == 0 && txEnable && !bufClose, "R1", "reset state",
        {queueHalted, evFlags, txEnable}, 3'b001);

    // R2/R4: mid-frame underrun
    curReq = "R2"; zeroSeen();
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    idle(8);
    chk(tailSeen == BEATS, "R2", "tail beats", tailSeen, BEATS);
    chk(killSeen == 1, "R2", "kill pulses", killSeen, 1);
    chk(closeSeen == 1 && evFlags == 3'b101, "R4", "underrun close/flags", evFlags, 5);
    recover();

    // R3: chain stall with chain complete is ignored, then real descriptor underrun
    curReq = "R3"; zeroSeen();
    step(1, 0, 1, 1, 0, 0, 0, 0);
    idle(2);
    chk(closeSeen == 0 && !queueHalted && evFlags == 0, "R3", "benign stall", closeSeen, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    idle(6);
    chk(tailSeen == 0 && killSeen == 0 && queueHalted, "R3", "no tail, halted",
        tailSeen + killSeen, 0);
    recover();

    // R5: retry limit
    curReq = "R5"; zeroSeen();
    step(1, 1, 1, 0, 1, 0, 0, 0);
    idle(6);
    chk(killSeen == 1 && tailSeen == 0 && evFlags == 3'b110, "R5", "retry flags", evFlags, 6);
    recover();

    // R6: underrun and retry limit in the same cycle
    curReq = "R6"; zeroSeen();
    step(0, 1, 0, 0, 1, 0, 0, 0);
    chk(bufRl && !bufUn, "R6", "retry status wins", {bufUn, bufRl}, 1);
    idle(6);
    chk(evFlags == 3'b111 && tailSeen == 0, "R6", "all flags, no tail", evFlags, 7);

    // R7: faults while halted are ignored (flags cleared while still halted)
    curReq = "R7";
    step(1, 0, 1, 0, 0, 0, 0, 3'b111);
    zeroSeen();
    step(0, 1, 0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    idle(5);
    chk(closeSeen == 0 && tailSeen == 0 && evFlags == 0, "R7", "ignored while halted",
        evFlags, 0);

    // R8: resume needs halt cleared and graceful stop low
    curReq = "R8";
    step(1, 0, 1, 0, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0, 0, 1, 0);
    chk(!queueHalted && !txEnable, "R8", "stop holds", txEnable, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0);
    chk(txEnable, "R8", "resumed", txEnable, 1);

    // R9: set beats clear in the same cycle, then clear later
    curReq = "R9";
    step(1, 1, 1, 0, 1, 0, 0, 3'b111);
    chk(evFlags == 3'b110, "R9", "set wins over clear", evFlags, 6);
    idle(3);
    chk(evFlags == 3'b110, "R9", "sticky", evFlags, 6);
    step(1, 0, 1, 0, 0, 0, 0, 3'b010);
    chk(evFlags == 3'b100, "R9", "partial clear", evFlags, 4);
    recover();
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule